// File: doc/BRIEF.md
# Programmable Logic Slice Cell

This block is a behavioural model of a single programmable logic cell. It is meant for building or checking a small reconfigurable fabric. It holds two 4-input lookup tables and a merge multiplexer that turns them into one 5-input function. A two-bit ripple-carry stage has a dedicated sum XOR and an optional AND term. Two storage elements sit behind the tables, and each can act as an edge-triggered flip-flop or as a level-sensitive latch.

One parallel write loads a configuration word. The word sets the table contents, the output selections, the carry term mode, the storage data source, the storage mode, and the polarity and timing of the shared control inputs. Carry enters at `cin` and passes through the lower bit (X) and then the upper bit (Y) to `cout`. This lets cells be stacked into wider adders or multiply-accumulate columns.

Top module: `slice_top`

## Requirements
- R1: A 46-bit configuration word is captured on a rising `clk` edge while `cfgWe` is 1. Its layout is as follows. Bits [15:0] hold table X and bits [31:16] hold table Y. Bits [33:32] hold the X output select and bit 34 holds the Y output select. Bits 35 and 36 enable the AND term for X and Y. Bits 37 and 38 choose the bypass storage input for X and Y. Bits 39 and 40 choose latch mode for X and Y. Bit 41 makes set synchronous and bit 42 makes reset synchronous. Bits 43, 44 and 45 invert clock-enable, set and reset.
- R2: Each table output is the table bit indexed by its 4-bit operand. X is indexed by `fIn` and Y by `gIn`. With X select 0, `xComb` shows table X. With Y select 0, `yComb` shows table Y.
- R3: With X select 1, `xComb` is a 5-input function: table Y when `bx` is 1, table X when `bx` is 0.
- R4: Carry runs only from `cin` through bit X, then bit Y, to `cout`. Each stage passes its incoming carry when its table output is 1. Otherwise it passes its generate term, which is operand bit 0.
- R5: The sum of each stage is its table output XOR its incoming carry. With X select 2 or 3, `xComb` shows the X sum. With Y select 1, `yComb` shows the Y sum.
- R6: With the AND-term bit set, a stage's generate term becomes operand bit 0 AND operand bit 1. One table per bit then completes a partial-product add.
- R7: Storage X takes `bx` when bypass is set and `xComb` otherwise. Storage Y takes `by` or `yComb` in the same way. In flip-flop mode, storage loads on the rising `clk` edge only while clock-enable is active, and holds its value otherwise.
- R8: In latch mode, storage follows its input while `clk` is 1 and clock-enable is active. It holds its value while `clk` is 0.
- R9: `ce`, `srSet` and `srRst` are shared by both storage elements. They are active high unless their inversion bit in R1 is set.
- R10: Set forces storage to 1 and reset forces it to 0. Each acts at the clock edge when its synchronous bit is set, or at once otherwise. Reset wins over set of the same kind. Synchronous set and reset act regardless of clock-enable.
- R11: Low `rstN` clears the configuration word to zero and both storage outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the latch gate |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 46 | Configuration word |
| fIn | input | 4 | Operand of table X |
| gIn | input | 4 | Operand of table Y |
| bx | input | 1 | Wide-mux select and bypass data for X |
| by | input | 1 | Bypass data for Y |
| cin | input | 1 | Carry from the cell below |
| ce | input | 1 | Shared clock-enable |
| srSet | input | 1 | Shared set control |
| srRst | input | 1 | Shared reset control |
| xComb | output | 1 | Unregistered X output |
| yComb | output | 1 | Unregistered Y output |
| xQ | output | 1 | Stored X output |
| yQ | output | 1 | Stored Y output |
| cout | output | 1 | Carry to the cell above |

## Verification
The assertions check several relations on every clock cycle. Carry passes straight through when both table outputs are 1. Carry is killed when the upper stage neither propagates nor generates. The wide multiplexer picks table Y when `bx` is high. An asynchronous clear keeps both outputs at 0, and a flip-flop with clock-enable off and only synchronous controls keeps its value. Other behaviour depends on timing within a cycle or on sweeps over many patterns, and only the bench scenarios show it. This covers latch transparency during the clock-high phase, a synchronous reset that waits for the edge, control inversion, reset-over-set priority, and the full arithmetic of the two-bit adder and multiply-add.

// File: rtl/slice_pkg.sv
package slice_pkg;
  localparam int LUT_K  = 4;
  localparam int TBL_W  = 1 << LUT_K;
  localparam int N_BITS = 2;

  typedef struct packed {
    logic             invRst;
    logic             invSet;
    logic             invCe;
    logic             syncRst;
    logic             syncSet;
    logic             latY;
    logic             latX;
    logic             bypY;
    logic             bypX;
    logic             andY;
    logic             andX;
    logic             ySel;
    logic [1:0]       xSel;
    logic [TBL_W-1:0] lutG;
    logic [TBL_W-1:0] lutF;
  } slice_cfg_t;

  localparam int CFG_W = $bits(slice_cfg_t);

  typedef struct packed {
    logic ceAct;
    logic clrAsync;
    logic preAsync;
    logic clrSync;
    logic preSync;
  } store_strb_t;
endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import slice_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             ce,
  input  logic             srSet,
  input  logic             srRst,
  output slice_cfg_t       cfg,
  output store_strb_t      strb
);
  logic ceLvl, setLvl, rstLvl;

  // configuration word register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfg <= '0;
    else if (cfgWe) cfg <= slice_cfg_t'(cfgData);
  end

  // per-control polarity
  assign ceLvl  = ce    ^ cfg.invCe;
  assign setLvl = srSet ^ cfg.invSet;
  assign rstLvl = srRst ^ cfg.invRst;

  // split set/reset into timing classes
  always_comb begin
    strb.ceAct    = ceLvl;
    strb.clrAsync = ~rstN | (rstLvl & ~cfg.syncRst);
    strb.preAsync = setLvl & ~cfg.syncSet;
    strb.clrSync  = rstLvl & cfg.syncRst;
    strb.preSync  = setLvl & cfg.syncSet;
  end
endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import slice_pkg::*;
(
  input  slice_cfg_t        cfg,
  input  logic [LUT_K-1:0]  fIn,
  input  logic [LUT_K-1:0]  gIn,
  input  logic              bx,
  input  logic              cin,
  output logic              xComb,
  output logic              yComb,
  output logic              cout,
  output logic [N_BITS-1:0] lutOut
);
  logic [LUT_K-1:0]  opIn   [N_BITS];
  logic [TBL_W-1:0]  tbl    [N_BITS];
  logic [N_BITS-1:0] andSel;
  logic [N_BITS-1:0] genTerm;
  logic [N_BITS-1:0] sumBit;
  logic [N_BITS:0]   chain;
  logic              wideOut;

  assign opIn[0] = fIn;
  assign opIn[1] = gIn;
  assign tbl[0]  = cfg.lutF;
  assign tbl[1]  = cfg.lutG;
  assign andSel  = {cfg.andY, cfg.andX};
  assign chain[0] = cin;

  // one table, generate term, carry mux and sum XOR per bit
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    assign lutOut[i]  = tbl[i][opIn[i]];
    assign genTerm[i] = andSel[i] ? (opIn[i][0] & opIn[i][1]) : opIn[i][0];
    assign chain[i+1] = lutOut[i] ? chain[i] : genTerm[i];
    assign sumBit[i]  = lutOut[i] ^ chain[i];
  end

  assign cout    = chain[N_BITS];
  assign wideOut = bx ? lutOut[1] : lutOut[0];

  always_comb begin
    case (cfg.xSel)
      2'd0:    xComb = lutOut[0];
      2'd1:    xComb = wideOut;
      default: xComb = sumBit[0];
    endcase
    yComb = cfg.ySel ? sumBit[1] : lutOut[1];
  end
endmodule

// File: rtl/slice_store.sv
module slice_store
  import slice_pkg::*;
(
  input  logic        clk,
  input  logic        latMode,
  input  logic        d,
  input  store_strb_t strb,
  output logic        q
);
  logic clrA, preA, clrS, preS, ceA;
  logic ffQ, latQ;

  assign clrA = strb.clrAsync;
  assign preA = strb.preAsync;
  assign clrS = strb.clrSync;
  assign preS = strb.preSync;
  assign ceA  = strb.ceAct;

  // edge-triggered variant
  always_ff @(posedge clk or posedge clrA or posedge preA) begin
    if (clrA)      ffQ <= 1'b0;
    else if (preA) ffQ <= 1'b1;
    else if (clrS) ffQ <= 1'b0;
    else if (preS) ffQ <= 1'b1;
    else if (ceA)  ffQ <= d;
  end

  // level-sensitive variant, open while clk is high
  always_latch begin
    if (clrA)      latQ = 1'b0;
    else if (preA) latQ = 1'b1;
    else if (clk) begin
      if (clrS)      latQ = 1'b0;
      else if (preS) latQ = 1'b1;
      else if (ceA)  latQ = d;
    end
  end

  assign q = latMode ? latQ : ffQ;
endmodule

// File: rtl/slice_top.sv
module slice_top
  import slice_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [slice_pkg::CFG_W-1:0] cfgData,
  input  logic [slice_pkg::LUT_K-1:0] fIn,
  input  logic [slice_pkg::LUT_K-1:0] gIn,
  input  logic                       bx,
  input  logic                       by,
  input  logic                       cin,
  input  logic                       ce,
  input  logic                       srSet,
  input  logic                       srRst,
  output logic                       xComb,
  output logic                       yComb,
  output logic                       xQ,
  output logic                       yQ,
  output logic                       cout
);
  slice_cfg_t        cfgQ;
  store_strb_t       strb;
  logic [N_BITS-1:0] lutOut;
  logic [N_BITS-1:0] dIn, latSel, qOut;

  slice_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .ce(ce), .srSet(srSet), .srRst(srRst), .cfg(cfgQ), .strb(strb)
  );

  slice_datapath dp_i (
    .cfg(cfgQ), .fIn(fIn), .gIn(gIn), .bx(bx), .cin(cin),
    .xComb(xComb), .yComb(yComb), .cout(cout), .lutOut(lutOut)
  );

  assign dIn[0]    = cfgQ.bypX ? bx : xComb;
  assign dIn[1]    = cfgQ.bypY ? by : yComb;
  assign latSel[0] = cfgQ.latX;
  assign latSel[1] = cfgQ.latY;

  for (genvar i = 0; i < N_BITS; i++) begin : g_store
    slice_store store_i (
      .clk(clk), .latMode(latSel[i]), .d(dIn[i]), .strb(strb), .q(qOut[i])
    );
  end

  assign xQ = qOut[0];
  assign yQ = qOut[1];
endmodule

// File: rtl/slice_checker.sv
module slice_checker
  import slice_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic              bx,
  input logic              cin,
  input logic [LUT_K-1:0]  gIn,
  input logic              xComb,
  input logic              xQ,
  input logic              yQ,
  input logic              cout,
  input logic [N_BITS-1:0] lutOut,
  input slice_cfg_t        cfg,
  input store_strb_t       strb
);
  a_r4_propagate: assert property (@(posedge clk) disable iff (!rstN)
    (lutOut == '1) |-> (cout == cin));

  a_r4_kill: assert property (@(posedge clk) disable iff (!rstN)
    (!lutOut[1] && !gIn[0]) |-> !cout);

  a_r3_wide_upper: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.xSel == 2'd1 && bx) |-> (xComb == lutOut[1]));

  a_r10_async_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAsync |-> (!xQ && !yQ));

  a_r7_ce_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ceAct && !strb.clrSync && !strb.preSync && cfg.syncSet && cfg.syncRst
     && !cfg.latX && !cfgWe) |=> $stable(xQ));
endmodule

bind slice_top slice_checker chk_i (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .bx(bx), .cin(cin), .gIn(gIn),
  .xComb(xComb), .xQ(xQ), .yQ(yQ), .cout(cout), .lutOut(lutOut),
  .cfg(cfgQ), .strb(strb)
);

// File: tb/slice_top_tb_top.sv
`timescale 1ns/1ps
module slice_top_tb_top;
  localparam int CW = 46;

  logic clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0;
  logic [CW-1:0] cfgData = '0;
  logic [3:0] fIn = '0, gIn = '0;
  logic bx = 0, by = 0, cin = 0, ce = 0, srSet = 0, srRst = 0;
  logic xComb, yComb, xQ, yQ, cout;
  int nVec = 0, nBad = 0;
  bit done = 0;

  slice_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .fIn(fIn), .gIn(gIn),
    .bx(bx), .by(by), .cin(cin), .ce(ce), .srSet(srSet), .srRst(srRst),
    .xComb(xComb), .yComb(yComb), .xQ(xQ), .yQ(yQ), .cout(cout)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // field positions per R1
  function automatic logic [CW-1:0] mk(input logic [15:0] tf, tg, input logic [1:0] xs,
      input logic ys, ax, ay, bpx, bpy, lx, ly, ss, sr, ic, is, ir);
    return {ir, is, ic, sr, ss, ly, lx, bpy, bpx, ay, ax, ys, xs, tg, tf};
  endfunction

  task automatic loadCfg(input logic [CW-1:0] w);
    @(negedge clk); cfgWe = 1'b1; cfgData = w;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] tf, tg, xorT, madT;
    tf = 16'hA55C; tg = 16'h3C81;
    for (int i = 0; i < 16; i++) begin
      xorT[i] = i[0] ^ i[1];
      madT[i] = (i[0] & i[1]) ^ i[2];
    end

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 xQ after reset", xQ, 1'b0);
    chk("R11 yQ after reset", yQ, 1'b0);
    rstN = 1'b1;
    #1 chk("R2 zero table", xComb, 1'b0);

    // R1/R2 plain table lookup
    loadCfg(mk(tf, tg, 2'd0, 0, 0,0, 0,0, 0,0, 1,1, 0,0,0));
    for (int f = 0; f < 16; f++) begin
      @(negedge clk); fIn = 4'(f); gIn = 4'(15 - f); #1;
      chk("R2 table X", xComb, tf[f]);
      chk("R2 table Y", yComb, tg[15 - f]);
    end

    // R3 five-input merge
    loadCfg(mk(tf, tg, 2'd1, 0, 0,0, 0,0, 0,0, 1,1, 0,0,0));
    for (int v = 0; v < 512; v++) begin
      @(negedge clk); fIn = v[3:0]; gIn = v[7:4]; bx = v[8]; #1;
      chk("R3 wide mux", xComb, v[8] ? tg[v[7:4]] : tf[v[3:0]]);
    end
    bx = 0;

    // R4/R5 two-bit adder
    loadCfg(mk(xorT, xorT, 2'd2, 1, 0,0, 0,0, 0,0, 1,1, 0,0,0));
    for (int v = 0; v < 32; v++) begin
      logic [2:0] s;
      @(negedge clk);
      fIn = {2'b00, v[2], v[0]}; gIn = {2'b00, v[3], v[1]}; cin = v[4]; #1;
      s = 3'(v[1:0]) + 3'(v[3:2]) + 3'(v[4]);
      chk("R5 sum X", xComb, s[0]);
      chk("R5 sum Y", yComb, s[1]);
      chk("R4 carry out", cout, s[2]);
    end

    // R6 multiply-add: a*b partial products plus c plus cin
    loadCfg(mk(madT, madT, 2'd3, 1, 1,1, 0,0, 0,0, 1,1, 0,0,0));
    for (int v = 0; v < 128; v++) begin
      logic [2:0] s;
      @(negedge clk);
      fIn = {1'b0, v[4], v[2], v[0]}; gIn = {1'b0, v[5], v[3], v[1]}; cin = v[6]; #1;
      s = 3'({v[1] & v[3], v[0] & v[2]}) + 3'(v[5:4]) + 3'(v[6]);
      chk("R6 madd X", xComb, s[0]);
      chk("R6 madd Y", yComb, s[1]);
      chk("R6 madd carry", cout, s[2]);
    end
    cin = 0; fIn = 0; gIn = 0;

    // R7 flip-flop capture and clock-enable
    loadCfg(mk(16'h0, 16'hAAAA, 2'd0, 0, 0,0, 1,0, 0,0, 1,1, 0,0,0));
    @(negedge clk); ce = 1; bx = 1; gIn = 4'd1; tick();
    chk("R7 capture bypass X", xQ, 1'b1);
    chk("R7 capture table Y", yQ, 1'b1);
    @(negedge clk); ce = 0; bx = 0; gIn = 4'd0; tick();
    chk("R7 hold X", xQ, 1'b1);
    chk("R7 hold Y", yQ, 1'b1);
    @(negedge clk); ce = 1; tick();
    chk("R7 reload X", xQ, 1'b0);

    // R10 synchronous reset/set and priority
    @(negedge clk); bx = 1; tick();
    @(negedge clk); srRst = 1; #1;
    chk("R10 sync reset waits", xQ, 1'b1);
    tick();
    chk("R10 sync reset at edge", xQ, 1'b0);
    @(negedge clk); srSet = 1; tick();
    chk("R10 reset beats set", xQ, 1'b0);
    @(negedge clk); srRst = 0; bx = 0; tick();
    chk("R10 sync set", xQ, 1'b1);
    @(negedge clk); srSet = 0; ce = 0; bx = 0;

    // R9 clock-enable inversion
    loadCfg(mk(16'h0, 16'hAAAA, 2'd0, 0, 0,0, 1,0, 0,0, 1,1, 1,0,0));
    tick();
    chk("R9 inverted ce active low", xQ, 1'b0);
    @(negedge clk); ce = 1; bx = 1; tick();
    chk("R9 inverted ce high holds", xQ, 1'b0);

    // R9 reset inversion
    loadCfg(mk(16'h0, 16'hAAAA, 2'd0, 0, 0,0, 1,0, 0,0, 1,1, 0,0,1));
    tick();
    chk("R9 inverted reset active", xQ, 1'b0);
    @(negedge clk); srRst = 1; tick();
    chk("R9 inverted reset idle", xQ, 1'b1);
    @(negedge clk); srRst = 0;

    // R10 asynchronous set/reset
    loadCfg(mk(16'h0, 16'hAAAA, 2'd0, 0, 0,0, 1,0, 0,0, 0,0, 0,0,0));
    @(negedge clk); ce = 1; bx = 1; tick();
    chk("R10 before async reset", xQ, 1'b1);
    @(negedge clk); srRst = 1; #1;
    chk("R10 async reset immediate", xQ, 1'b0);
    srRst = 0; bx = 0; srSet = 1; #1;
    chk("R10 async set immediate", xQ, 1'b1);
    srRst = 1; #1;
    chk("R10 async reset beats set", xQ, 1'b0);
    srRst = 0; srSet = 0;

    // R8 latch mode
    loadCfg(mk(16'h0, 16'hAAAA, 2'd0, 0, 0,0, 1,0, 1,0, 1,1, 0,0,0));
    @(negedge clk); ce = 1; bx = 0;
    @(posedge clk); #0.5 bx = 1; #0.5;
    chk("R8 transparent while high", xQ, 1'b1);
    @(negedge clk); #0.5 bx = 0; #0.5;
    chk("R8 holds while low", xQ, 1'b1);
    @(posedge clk); #1;
    chk("R8 reopens", xQ, 1'b0);
    @(negedge clk); ce = 0;
    @(posedge clk); #0.5 bx = 1; #0.5;
    chk("R8 closed when ce off", xQ, 1'b0);

    // R11 reset clears configuration and storage
    loadCfg(mk(16'hFFFF, 16'h0, 2'd0, 0, 0,0, 1,0, 0,0, 1,1, 0,0,0));
    @(negedge clk); ce = 1; bx = 1; fIn = 0; tick();
    chk("R11 pre-reset table", xComb, 1'b1);
    chk("R11 pre-reset store", xQ, 1'b1);
    @(negedge clk); rstN = 0; #1;
    chk("R11 table cleared", xComb, 1'b0);
    chk("R11 store cleared", xQ, 1'b0);
    @(negedge clk); rstN = 1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule